// File: doc/BRIEF.md
# Multiply, Multiply-Accumulate and Divide Unit

This block is an arithmetic helper that sits on a simple register bus beside a processor. Software picks one of three kinds of work through an 8-bit control register: a 16 x 16 multiply, the same multiply with the product added into a 32-bit accumulator, or a 32 / 32 unsigned divide. The control register also carries the signed/unsigned choice, a divide start/busy bit, and the sticky overflow and sign flags of the accumulator.

A multiply or multiply-accumulate happens in the clock edge that writes the operand word, so the product and the accumulator are ready on the next read. A divide is started by a control write and then runs one quotient bit per cycle for 32 cycles. When it finishes, the start bit drops and, in one of the two divide modes, a one-cycle completion pulse is raised. All registers are one 32-bit word each, written through per-byte enables, and read data comes out one cycle after the address.

Top module: `mdac_unit`

## Requirements
- R1: After reset the control word, product, accumulator, quotient and remainder all read 0 and `div_irq` is low.
- R2: Control word (address 0, lane 0 only) layout: bit 7 divide select, bit 6 accumulate select, bit 3 signed select, bit 2 overflow flag, bit 1 sign flag, bit 0 divide start/busy; bits 5:4 ignore writes and read 0. Legal {bit7,bit6,bit3} codes are 000 unsigned multiply, 001 signed multiply, 010 unsigned accumulate, 011 signed accumulate, 100 divide with pulse, 110 divide without pulse; writing 101 or 111 leaves the previous code in effect.
- R3: In a multiply code, writing the operand word (address 1; bits 15:0 first operand, bits 31:16 second operand) loads the product register (address 2) with the 32-bit unsigned or two's-complement product.
- R4: In an accumulate code, the operand write also adds that product into the accumulator (address 3), which software can load directly.
- R5: In unsigned accumulate, a carry out of bit 31 sets the overflow flag, and the sign flag reads 0.
- R6: In signed accumulate, the overflow flag is set when two non-negative values sum to a negative result or two negative values sum to a non-negative one; the sign flag reads accumulator bit 31.
- R7: The overflow flag stays set until a control write with bit 2 at 0 or reset; a control write with bit 2 at 1 never sets it.
- R8: In a divide code, writing bit 0 as 1 starts an unsigned divide of address 4 by address 5; bit 0 reads 1 for 32 cycles, after which quotient (address 6) and remainder (address 7) are valid and bit 0 reads 0.
- R9: At divide completion `div_irq` pulses high for exactly one cycle under code 100 and stays low under code 110.
- R10: Division by zero gives a quotient of all ones and a remainder equal to the dividend, and completes normally.
- R11: A start bit written outside a divide code does nothing; while a divide runs, further start writes and code changes are ignored.
- R12: An operand write in a divide code changes neither the product nor the accumulator.
- R13: Only the byte lanes whose enable is set change on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Register word address |
| bus_be | input | 4 | Byte lane enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, one cycle after address |
| div_irq | output | 1 | One-cycle divide completion pulse |

## Verification
The embedded properties assume reset is held for at least one edge before any access and that the bus carries at most one write per cycle, so a register is never written and computed from two sources at once. They also take for granted that software does not clear the overflow flag in the same cycle an accumulate overflows; if it did, setting wins. The stimulus keeps to this by issuing every access through one task that spends one full clock per write, always under a reset-established state, and by spacing flag-clearing writes away from accumulate operations.

// File: rtl/mdac_pkg.sv
package mdac_pkg;

  typedef enum logic [2:0] {
    MODE_MUL_U     = 3'b000,
    MODE_MUL_S     = 3'b001,
    MODE_MAC_U     = 3'b010,
    MODE_MAC_S     = 3'b011,
    MODE_DIV_IRQ   = 3'b100,
    MODE_DIV_QUIET = 3'b110
  } mode_e;

  // control word bit positions
  localparam int CB_DIV  = 7;
  localparam int CB_MAC  = 6;
  localparam int CB_SGN  = 3;
  localparam int CB_OVF  = 2;
  localparam int CB_GO   = 0;

  // register word addresses
  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_OPS  = 3'd1;
  localparam logic [2:0] RA_PROD = 3'd2;
  localparam logic [2:0] RA_ACC  = 3'd3;
  localparam logic [2:0] RA_DVD  = 3'd4;
  localparam logic [2:0] RA_DVS  = 3'd5;
  localparam logic [2:0] RA_QUO  = 3'd6;
  localparam logic [2:0] RA_REM  = 3'd7;

  function automatic logic mode_ok(input logic [2:0] m);
    return (m != 3'b101) && (m != 3'b111);
  endfunction

endpackage

// File: rtl/mdac_ctrl.sv
module mdac_ctrl
  import mdac_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic       w_div,
  input  logic       w_mac,
  input  logic       w_sgn,
  input  logic       w_ovf,
  input  logic       w_go,
  input  logic       div_busy,
  input  logic       ovf_hit,
  output logic [2:0] mode,
  output logic       ovf,
  output logic       go
);

  logic [2:0] req;
  logic       take;
  logic [2:0] mode_nx;

  assign req     = {w_div, w_mac, w_sgn};
  assign take    = wr && !div_busy && mode_ok(req);
  assign mode_nx = take ? req : mode;
  assign go      = wr && w_go && !div_busy && mode_nx[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= MODE_MUL_U;
      ovf  <= 1'b0;
    end else begin
      mode <= mode_nx;
      if (ovf_hit)
        ovf <= 1'b1;
      else if (wr && !w_ovf)
        ovf <= 1'b0;
    end
  end

  assert_mode_legal_R2: assert property (@(posedge clk) disable iff (rst)
    mode_ok(mode));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (ovf && !(wr && !w_ovf)) |=> ovf);

  assert_mode_frozen_R11: assert property (@(posedge clk) disable iff (rst)
    div_busy |=> $stable(mode));

endmodule

// File: rtl/mdac_mac.sv
module mdac_mac #(
  parameter int OP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              acc_mode,
  input  logic              sgn,
  input  logic [OP_W-1:0]   opa,
  input  logic [OP_W-1:0]   opb,
  input  logic              acc_wr,
  input  logic [OP_W/4-1:0] acc_be,
  input  logic [2*OP_W-1:0] acc_wd,
  output logic [2*OP_W-1:0] product,
  output logic [2*OP_W-1:0] acc,
  output logic              ovf_hit
);

  localparam int DW = 2 * OP_W;
  localparam int NB = DW / 8;

  logic [DW-1:0] ext_a, ext_b, prod;
  logic [DW:0]   sum;
  logic          ovf_u, ovf_s;

  always_comb begin
    ext_a = sgn ? {{OP_W{opa[OP_W-1]}}, opa} : {{OP_W{1'b0}}, opa};
    ext_b = sgn ? {{OP_W{opb[OP_W-1]}}, opb} : {{OP_W{1'b0}}, opb};
    prod  = ext_a * ext_b;
    sum   = {1'b0, acc} + {1'b0, prod};
    ovf_u = sum[DW];
    ovf_s = (!acc[DW-1] && !prod[DW-1] &&  sum[DW-1]) ||
            ( acc[DW-1] &&  prod[DW-1] && !sum[DW-1]);
  end

  assign ovf_hit = fire && acc_mode && (sgn ? ovf_s : ovf_u);

  always_ff @(posedge clk) begin
    if (rst) begin
      product <= '0;
      acc     <= '0;
    end else begin
      if (fire)
        product <= prod;
      if (fire && acc_mode)
        acc <= sum[DW-1:0];
      else if (acc_wr) begin
        for (int i = 0; i < NB; i++)
          if (acc_be[i]) acc[i*8 +: 8] <= acc_wd[i*8 +: 8];
      end
    end
  end

  assert_acc_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!fire && !acc_wr) |=> $stable(acc));

  assert_prod_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(product));

endmodule

// File: rtl/mdac_div.sv
module mdac_div #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          irq_en,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          busy,
  output logic          irq,
  output logic [DW-1:0] quot,
  output logic [DW-1:0] rem
);

  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] cnt;
  logic [DW-1:0] qw, rw, dw;
  logic [DW:0]   shifted, diff;
  logic          fits;
  logic [DW-1:0] q_n, r_n;

  always_comb begin
    shifted = {rw, qw[DW-1]};
    diff    = shifted - {1'b0, dw};
    fits    = !diff[DW];
    r_n     = fits ? diff[DW-1:0] : shifted[DW-1:0];
    q_n     = {qw[DW-2:0], fits};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      irq  <= 1'b0;
      cnt  <= '0;
      qw   <= '0;
      rw   <= '0;
      dw   <= '0;
      quot <= '0;
      rem  <= '0;
    end else begin
      irq <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        cnt  <= '0;
        qw   <= dividend;
        rw   <= '0;
        dw   <= divisor;
      end else if (busy) begin
        qw <= q_n;
        rw <= r_n;
        if (cnt == LAST) begin
          busy <= 1'b0;
          quot <= q_n;
          rem  <= r_n;
          irq  <= irq_en;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_busy_span_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != LAST) |=> busy);

  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_div_zero_R10: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && dw == '0) |-> (quot == '1));

endmodule

// File: rtl/mdac_unit.sv
module mdac_unit
  import mdac_pkg::*;
#(
  parameter int OP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [OP_W/4-1:0] bus_be,
  input  logic [2*OP_W-1:0] bus_wdata,
  output logic [2*OP_W-1:0] bus_rdata,
  output logic              div_irq
);

  localparam int DW = 2 * OP_W;
  localparam int NB = DW / 8;

  logic          wr_ctrl, wr_ops, wr_acc, wr_dvd, wr_dvs;
  logic [2:0]    mode;
  logic          ovf, go, busy, ovf_hit, fire, sign_flag;
  logic [DW-1:0] ops_q, ops_nx, dvd_q, dvs_q;
  logic [DW-1:0] product, acc, quot, rem;
  logic [7:0]    ctrl_rd;

  assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL) && bus_be[0];
  assign wr_ops  = bus_wr && (bus_addr == RA_OPS);
  assign wr_acc  = bus_wr && (bus_addr == RA_ACC);
  assign wr_dvd  = bus_wr && (bus_addr == RA_DVD);
  assign wr_dvs  = bus_wr && (bus_addr == RA_DVS);

  always_comb begin
    ops_nx = ops_q;
    for (int i = 0; i < NB; i++)
      if (bus_be[i]) ops_nx[i*8 +: 8] = bus_wdata[i*8 +: 8];
  end

  assign fire = wr_ops && !mode[2];

  mdac_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr       (wr_ctrl),
    .w_div    (bus_wdata[CB_DIV]),
    .w_mac    (bus_wdata[CB_MAC]),
    .w_sgn    (bus_wdata[CB_SGN]),
    .w_ovf    (bus_wdata[CB_OVF]),
    .w_go     (bus_wdata[CB_GO]),
    .div_busy (busy),
    .ovf_hit  (ovf_hit),
    .mode     (mode),
    .ovf      (ovf),
    .go       (go)
  );

  mdac_mac #(.OP_W(OP_W)) u_mac (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .acc_mode (mode[1] && !mode[2]),
    .sgn      (mode[0]),
    .opa      (ops_nx[OP_W-1:0]),
    .opb      (ops_nx[DW-1:OP_W]),
    .acc_wr   (wr_acc),
    .acc_be   (bus_be),
    .acc_wd   (bus_wdata),
    .product  (product),
    .acc      (acc),
    .ovf_hit  (ovf_hit)
  );

  mdac_div #(.DW(DW)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (go),
    .irq_en   (mode == MODE_DIV_IRQ),
    .dividend (dvd_q),
    .divisor  (dvs_q),
    .busy     (busy),
    .irq      (div_irq),
    .quot     (quot),
    .rem      (rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ops_q <= '0;
      dvd_q <= '0;
      dvs_q <= '0;
    end else begin
      if (wr_ops) ops_q <= ops_nx;
      for (int i = 0; i < NB; i++) begin
        if (wr_dvd && bus_be[i]) dvd_q[i*8 +: 8] <= bus_wdata[i*8 +: 8];
        if (wr_dvs && bus_be[i]) dvs_q[i*8 +: 8] <= bus_wdata[i*8 +: 8];
      end
    end
  end

  assign sign_flag = (mode == MODE_MAC_S) ? acc[DW-1] : 1'b0;
  assign ctrl_rd   = {mode[2], mode[1], 2'b00, mode[0], ovf, sign_flag, busy};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        RA_CTRL: bus_rdata <= {{(DW-8){1'b0}}, ctrl_rd};
        RA_OPS:  bus_rdata <= ops_q;
        RA_PROD: bus_rdata <= product;
        RA_ACC:  bus_rdata <= acc;
        RA_DVD:  bus_rdata <= dvd_q;
        RA_DVS:  bus_rdata <= dvs_q;
        RA_QUO:  bus_rdata <= quot;
        default: bus_rdata <= rem;
      endcase
    end
  end

  assert_irq_mode_R9: assert property (@(posedge clk) disable iff (rst)
    div_irq |-> (mode == MODE_DIV_IRQ));

  assert_div_ops_inert_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_ops && mode[2]) |=> ($stable(product) && $stable(acc)));

  assert_go_needs_div_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> mode[2]);

endmodule

// File: tb/mdac_unit_bench.sv
`timescale 1ns/1ps
module mdac_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [3:0]  bus_be = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        div_irq;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mdac_unit u_mdac_unit (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .div_irq(div_irq)
  );

  // {signed, second operand, first operand}
  localparam logic [32:0] MUL_VEC [8] = '{
    {1'b0, 16'hFFFF, 16'hFFFF},
    {1'b0, 16'h0010, 16'h1234},
    {1'b0, 16'hABCD, 16'h0000},
    {1'b0, 16'h0002, 16'h8000},
    {1'b1, 16'hFFFF, 16'hFFFF},
    {1'b1, 16'h8000, 16'h8000},
    {1'b1, 16'h7FFF, 16'h8000},
    {1'b1, 16'h0003, 16'hFFFE}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'd0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, expv, p_keep;
    longint sa, sb;
    int hits;
    logic [31:0] dvd_t [4];
    logic [31:0] dvs_t [4];
    dvd_t = '{32'd1000, 32'hFFFFFFFF, 32'd5, 32'h12345678};
    dvs_t = '{32'd7,    32'h00010000, 32'd9, 32'd0};

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'd0, div_irq}, 32'd0);
    rd(3'd0, v); check("R1 ctrl", v, 32'h0);
    rd(3'd2, v); check("R1 product", v, 32'h0);
    rd(3'd3, v); check("R1 acc", v, 32'h0);
    rd(3'd6, v); check("R1 quotient", v, 32'h0);
    rd(3'd7, v); check("R1 remainder", v, 32'h0);

    // R3 multiply table
    foreach (MUL_VEC[k]) begin
      wr(3'd0, MUL_VEC[k][32] ? 32'h08 : 32'h00, 4'hF);
      wr(3'd1, MUL_VEC[k][31:0], 4'hF);
      sa = MUL_VEC[k][32] ? longint'($signed(MUL_VEC[k][15:0]))  : longint'(MUL_VEC[k][15:0]);
      sb = MUL_VEC[k][32] ? longint'($signed(MUL_VEC[k][31:16])) : longint'(MUL_VEC[k][31:16]);
      expv = 32'(sa * sb);
      rd(3'd2, v); check("R3 product", v, expv);
    end

    // R13 byte lanes on the operand word and control word
    wr(3'd0, 32'h00, 4'hF);
    wr(3'd1, 32'h00030005, 4'hF);
    wr(3'd1, 32'h00FF0000, 4'b0100);
    rd(3'd1, v); check("R13 operand lanes", v, 32'h00FF0005);
    rd(3'd2, v); check("R13 product after lane write", v, 32'd1275);
    wr(3'd0, 32'h40, 4'b1110);
    rd(3'd0, v); check("R13 ctrl lane0 only", v, 32'h00);

    // R4 R5 unsigned accumulate
    wr(3'd0, 32'h40, 4'hF);
    wr(3'd3, 32'hFFFFFF00, 4'hF);
    wr(3'd1, 32'h000F0010, 4'hF);
    rd(3'd3, v); check("R4 acc sum", v, 32'hFFFFFFF0);
    rd(3'd0, v); check("R5 no overflow yet", v, 32'h40);
    wr(3'd1, 32'h00040004, 4'hF);
    rd(3'd3, v); check("R5 acc wraps", v, 32'h0);
    rd(3'd2, v); check("R4 product in acc mode", v, 32'h10);
    rd(3'd0, v); check("R5 overflow set sign 0", v, 32'h44);

    // R7 sticky overflow
    wr(3'd1, 32'h00010001, 4'hF);
    rd(3'd0, v); check("R7 still set", v, 32'h44);
    wr(3'd0, 32'h44, 4'hF);
    rd(3'd0, v); check("R7 write one keeps", v, 32'h44);
    wr(3'd0, 32'h40, 4'hF);
    rd(3'd0, v); check("R7 cleared", v, 32'h40);
    wr(3'd0, 32'h44, 4'hF);
    rd(3'd0, v); check("R7 write one does not set", v, 32'h40);

    // R6 signed accumulate
    wr(3'd0, 32'h48, 4'hF);
    wr(3'd3, 32'h7FFF0000, 4'hF);
    wr(3'd1, 32'h00027FFF, 4'hF);
    rd(3'd3, v); check("R6 acc", v, 32'h7FFFFFFE);
    rd(3'd0, v); check("R6 no overflow", v, 32'h48);
    wr(3'd1, 32'h00010002, 4'hF);
    rd(3'd3, v); check("R6 acc crosses", v, 32'h80000000);
    rd(3'd0, v); check("R6 pos overflow and sign", v, 32'h4E);
    wr(3'd0, 32'h48, 4'hF);
    rd(3'd0, v); check("R6 sign after clear", v, 32'h4A);
    wr(3'd1, 32'h0001FFFF, 4'hF);
    rd(3'd3, v); check("R6 acc neg wrap", v, 32'h7FFFFFFF);
    rd(3'd0, v); check("R6 neg overflow", v, 32'h4C);

    // R2 prohibited codes and reserved bits
    wr(3'd0, 32'h08, 4'hF);
    rd(3'd0, v); check("R2 legal code", v, 32'h08);
    wr(3'd0, 32'hC8, 4'hF);
    rd(3'd0, v); check("R2 code 111 rejected", v, 32'h08);
    wr(3'd0, 32'h88, 4'hF);
    rd(3'd0, v); check("R2 code 101 rejected", v, 32'h08);
    wr(3'd0, 32'h78, 4'hF);
    rd(3'd0, v); check("R2 reserved ignored", v, 32'h48);

    // R11 start outside divide code
    wr(3'd4, 32'd100, 4'hF);
    wr(3'd5, 32'd3, 4'hF);
    wr(3'd0, 32'h01, 4'hF);
    rd(3'd0, v); check("R11 start ignored", v, 32'h00);
    hits = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (div_irq) hits++; end
    check("R11 no pulse", 32'(hits), 32'd0);
    rd(3'd6, v); check("R11 quotient untouched", v, 32'h0);

    // R12 operand write in divide code
    rd(3'd2, p_keep);
    wr(3'd0, 32'h80, 4'hF);
    wr(3'd1, 32'h00090009, 4'hF);
    rd(3'd2, v); check("R12 product kept", v, p_keep);
    rd(3'd3, v); check("R12 acc kept", v, 32'h7FFFFFFF);

    // R8 R9 R10 divide vectors, code 100
    for (int k = 0; k < 4; k++) begin
      wr(3'd4, dvd_t[k], 4'hF);
      wr(3'd5, dvs_t[k], 4'hF);
      wr(3'd0, 32'h81, 4'hF);
      idle(31);
      check("R8 not done after 31", {31'd0, div_irq}, 32'd0);
      idle(1);
      check("R9 pulse at 32", {31'd0, div_irq}, 32'd1);
      idle(1);
      check("R9 pulse one cycle", {31'd0, div_irq}, 32'd0);
      rd(3'd0, v); check("R8 busy cleared", v, 32'h80);
      expv = (dvs_t[k] == 0) ? 32'hFFFFFFFF : dvd_t[k] / dvs_t[k];
      rd(3'd6, v); check(k == 3 ? "R10 quotient" : "R8 quotient", v, expv);
      expv = (dvs_t[k] == 0) ? dvd_t[k] : dvd_t[k] % dvs_t[k];
      rd(3'd7, v); check(k == 3 ? "R10 remainder" : "R8 remainder", v, expv);
    end

    // R11 writes while busy
    wr(3'd4, 32'd1000, 4'hF);
    wr(3'd5, 32'd7, 4'hF);
    wr(3'd0, 32'h81, 4'hF);
    idle(5);
    wr(3'd0, 32'h01, 4'hF);
    rd(3'd0, v); check("R11 code frozen while busy", v, 32'h81);
    idle(24);
    check("R11 no early end", {31'd0, div_irq}, 32'd0);
    idle(1);
    check("R11 no restart", {31'd0, div_irq}, 32'd1);

    // R9 quiet divide code
    wr(3'd4, 32'd77, 4'hF);
    wr(3'd5, 32'd10, 4'hF);
    wr(3'd0, 32'hC1, 4'hF);
    hits = 0;
    for (int i = 0; i < 36; i++) begin @(negedge clk); if (div_irq) hits++; end
    check("R9 quiet code no pulse", 32'(hits), 32'd0);
    rd(3'd0, v); check("R9 quiet done", v, 32'hC0);
    rd(3'd6, v); check("R9 quiet quotient", v, 32'd7);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule